// File: doc/BRIEF.md
# Stripmined Vector Loop Sequencer

This block runs a loop over an element count of any size on a vector unit with a fixed maximum vector length. It cuts the count into strips. For each strip it presents a length and three operand addresses: two source streams and one destination stream. It waits for the consumer to report that the strip is finished, then moves every address forward by the bytes that strip covered. The odd-sized remainder strip goes out first. Every strip after it has the full maximum length, so the rest of the loop runs with no length changes.

A sequence starts with a one-cycle `start` pulse, which loads the count and the three base addresses. Each strip is held on the outputs until `strip_ack` arrives. After the final acknowledge, `done` pulses for one cycle. A zero count produces `done` at once and issues no strip. The vector operation itself runs outside this block.

Top module: `vstrip_seq`

## Requirements
- R1: After reset, `strip_valid` and `done` are both low.
- R2: The first strip length equals N mod MAX_VL. Every later strip length equals MAX_VL (64). `strip_len` carries the element count as an unsigned number.
- R3: When N is a non-zero multiple of MAX_VL, the zero-length first strip is skipped, so every strip, including the first, has length MAX_VL.
- R4: The first strip's three addresses equal the base inputs latched at `start`. Each later strip's addresses equal the previous strip's addresses plus the previous strip length times ELEM_BYTES (8).
- R5: While `strip_valid` is high and `strip_ack` is low, the strip length and all three addresses stay unchanged and `strip_valid` stays high.
- R6: The next strip appears in the cycle after an acknowledge. A sequence issues exactly ceil(N / MAX_VL) strips.
- R7: In the cycle after the final strip's acknowledge, `done` is high and `strip_valid` is low. In the following cycle, `done` is low again.
- R8: When N is zero, `done` is high in the cycle after `start` and no strip is issued.
- R9: A `start` pulse that arrives while a sequence is in progress is ignored. The strips already under way continue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a sequence when the block is idle |
| count | input | CNT_W | Total element count N |
| src_a_base | input | PTR_W | Byte address of the first source stream |
| src_b_base | input | PTR_W | Byte address of the second source stream |
| dst_base | input | PTR_W | Byte address of the destination stream |
| strip_valid | output | 1 | A strip is being offered |
| strip_len | output | LEN_W | Element count of the current strip |
| strip_src_a | output | PTR_W | First source address for the current strip |
| strip_src_b | output | PTR_W | Second source address for the current strip |
| strip_dst | output | PTR_W | Destination address for the current strip |
| strip_ack | input | 1 | Consumer has finished the current strip |
| done | output | 1 | One-cycle pulse at the end of a sequence |

## Verification
The assertions assume that `strip_ack` is raised only while `strip_valid` is high and lasts one cycle. The stimulus keeps to this by raising the acknowledge only after it has seen a valid strip, and by dropping it on the next cycle. Some `start` pulses are deliberately issued during a sequence to exercise R9. The assertions stay sound under these pulses because the block must ignore them. Element counts are kept small enough that addresses never wrap. The assertion on address steps therefore compares exact sums.

// File: rtl/vstrip_seq.sv
module vstrip_seq #(
  parameter int MAX_VL     = 64,
  parameter int CNT_W      = 16,
  parameter int PTR_W      = 32,
  parameter int ELEM_BYTES = 8,
  localparam int VL_LOG    = $clog2(MAX_VL),
  localparam int LEN_W     = VL_LOG + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] count,
  input  logic [PTR_W-1:0] src_a_base,
  input  logic [PTR_W-1:0] src_b_base,
  input  logic [PTR_W-1:0] dst_base,
  output logic             strip_valid,
  output logic [LEN_W-1:0] strip_len,
  output logic [PTR_W-1:0] strip_src_a,
  output logic [PTR_W-1:0] strip_src_b,
  output logic [PTR_W-1:0] strip_dst,
  input  logic             strip_ack,
  output logic             done
);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} state_t;

  localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(MAX_VL);

  state_t           state;
  logic [CNT_W-1:0] remain;
  logic [CNT_W-1:0] remain_next;
  logic [LEN_W-1:0] first_len;
  logic [PTR_W-1:0] bump;

  assign first_len   = (count[VL_LOG-1:0] == '0) ? FULL_LEN : {1'b0, count[VL_LOG-1:0]};
  assign remain_next = remain - CNT_W'(strip_len);
  assign bump        = PTR_W'(strip_len) * PTR_W'(ELEM_BYTES);
  assign strip_valid = (state == S_RUN);
  assign done        = (state == S_FIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      remain      <= '0;
      strip_len   <= '0;
      strip_src_a <= '0;
      strip_src_b <= '0;
      strip_dst   <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          remain      <= count;
          strip_len   <= first_len;
          strip_src_a <= src_a_base;
          strip_src_b <= src_b_base;
          strip_dst   <= dst_base;
          state       <= (count == '0) ? S_FIN : S_RUN;
        end
        S_RUN: if (strip_ack) begin
          remain      <= remain_next;
          strip_src_a <= strip_src_a + bump;
          strip_src_b <= strip_src_b + bump;
          strip_dst   <= strip_dst + bump;
          strip_len   <= FULL_LEN;
          if (remain_next == '0) state <= S_FIN;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/vstrip_seq_chk.sv
module vstrip_seq_chk #(
  parameter int MAX_VL     = 64,
  parameter int LEN_W      = 7,
  parameter int PTR_W      = 32,
  parameter int ELEM_BYTES = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             strip_valid,
  input logic [LEN_W-1:0] strip_len,
  input logic [PTR_W-1:0] strip_src_a,
  input logic [PTR_W-1:0] strip_src_b,
  input logic [PTR_W-1:0] strip_dst,
  input logic             strip_ack,
  input logic             done
);

  p_len_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strip_valid |-> (strip_len != '0) && (strip_len <= LEN_W'(MAX_VL)));

  p_full_after_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strip_valid && strip_ack |=> !strip_valid || (strip_len == LEN_W'(MAX_VL)));

  p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strip_valid && strip_ack |=> !strip_valid ||
      ((strip_src_a == $past(strip_src_a) + PTR_W'($past(strip_len)) * PTR_W'(ELEM_BYTES)) &&
       (strip_src_b == $past(strip_src_b) + PTR_W'($past(strip_len)) * PTR_W'(ELEM_BYTES)) &&
       (strip_dst   == $past(strip_dst)   + PTR_W'($past(strip_len)) * PTR_W'(ELEM_BYTES))));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strip_valid && !strip_ack |=> strip_valid && $stable(strip_len) &&
      $stable(strip_src_a) && $stable(strip_src_b) && $stable(strip_dst));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && strip_valid));

endmodule

bind vstrip_seq vstrip_seq_chk #(
  .MAX_VL(MAX_VL), .LEN_W(LEN_W), .PTR_W(PTR_W), .ELEM_BYTES(ELEM_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .strip_valid(strip_valid), .strip_len(strip_len),
  .strip_src_a(strip_src_a), .strip_src_b(strip_src_b), .strip_dst(strip_dst),
  .strip_ack(strip_ack), .done(done)
);

// File: tb/vstrip_seq_tb.sv
module vstrip_seq_tb;
  localparam int MAX_VL = 64;
  localparam int CNT_W  = 16;
  localparam int PTR_W  = 32;
  localparam int EB     = 8;
  localparam int LEN_W  = 7;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [CNT_W-1:0] count = '0;
  logic [PTR_W-1:0] a_base = '0, b_base = '0, d_base = '0;
  logic             strip_valid, done;
  logic [LEN_W-1:0] strip_len;
  logic [PTR_W-1:0] s_a, s_b, s_d;
  logic             strip_ack = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  vstrip_seq #(.MAX_VL(MAX_VL), .CNT_W(CNT_W), .PTR_W(PTR_W), .ELEM_BYTES(EB)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .count(count),
    .src_a_base(a_base), .src_b_base(b_base), .dst_base(d_base),
    .strip_valid(strip_valid), .strip_len(strip_len),
    .strip_src_a(s_a), .strip_src_b(s_b), .strip_dst(s_d),
    .strip_ack(strip_ack), .done(done));

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int first_len(input int n);
    return (n % MAX_VL == 0) ? MAX_VL : n % MAX_VL;
  endfunction

  function automatic int num_strips(input int n);
    return (n + MAX_VL - 1) / MAX_VL;
  endfunction

  task automatic run_job(input int n, input bit busy_start, input int max_wait);
    int ea, eb, ed, len, ns;
    ea = int'($urandom_range(0, 32'h0fff_ffff)) & ~7;
    eb = int'($urandom_range(0, 32'h0fff_ffff)) & ~7;
    ed = int'($urandom_range(0, 32'h0fff_ffff)) & ~7;
    ns = num_strips(n);
    @(negedge clk);
    start = 1'b1; count = CNT_W'(n);
    a_base = PTR_W'(ea); b_base = PTR_W'(eb); d_base = PTR_W'(ed);
    @(negedge clk);
    start = 1'b0;
    if (n == 0) begin
      check(done == 1'b1, "R8 done after zero count", done, 1);
      check(strip_valid == 1'b0, "R8 no strip", strip_valid, 0);
      @(negedge clk);
      check(done == 1'b0 && strip_valid == 1'b0, "R8 quiet after done", done, 0);
      return;
    end
    len = first_len(n);
    for (int s = 0; s < ns; s++) begin
      int w;
      check(strip_valid == 1'b1, "R6 strip present", strip_valid, 1);
      check(int'(strip_len) == len, (n % MAX_VL == 0) ? "R3 strip length" : "R2 strip length",
            strip_len, len);
      check(int'(s_a) == ea && int'(s_b) == eb && int'(s_d) == ed, "R4 addresses",
            s_a, ea);
      check(done == 1'b0, "R7 no early done", done, 0);
      w = int'($urandom_range(0, max_wait));
      for (int k = 0; k < w; k++) begin
        if (busy_start && k == 0) begin
          start = 1'b1; count = CNT_W'(5); a_base = 32'h4000; b_base = 32'h8000; d_base = 32'hc000;
        end
        @(negedge clk);
        start = 1'b0;
        check(strip_valid && int'(strip_len) == len && int'(s_a) == ea && int'(s_d) == ed,
              busy_start ? "R9 hold despite start" : "R5 hold", s_a, ea);
      end
      strip_ack = 1'b1;
      @(negedge clk);
      strip_ack = 1'b0;
      ea += len * EB; eb += len * EB; ed += len * EB;
      len = MAX_VL;
    end
    check(done == 1'b1, "R7 done after last ack", done, 1);
    check(strip_valid == 1'b0, "R7 strips end", strip_valid, 0);
    @(negedge clk);
    check(done == 1'b0, "R7 done single cycle", done, 0);
  endtask

  initial begin
    #500000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(strip_valid == 1'b0, "R1 reset valid", strip_valid, 0);
    check(done == 1'b0, "R1 reset done", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(strip_valid == 1'b0 && done == 1'b0, "R1 idle after reset", strip_valid, 0);

    run_job(0, 0, 0);
    run_job(1, 0, 2);
    run_job(63, 0, 1);
    run_job(64, 0, 2);
    run_job(65, 0, 0);
    run_job(128, 0, 3);
    run_job(200, 1, 3);
    run_job(130, 1, 2);
    for (int j = 0; j < 40; j++)
      run_job(int'($urandom_range(0, 400)), j % 5 == 0, 4);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule